// File: doc/BRIEF.md
# I2C Target Register Bank

This block is an I2C target that gives a bus controller access to a bank of eight-bit registers (256 of them by default). The block samples SCL and SDA on its own system clock, spots START, repeated START and STOP conditions, and compares the first byte of each transfer with a 7-bit device address that is set as a parameter. When the address matches, the block acknowledges. For any other address it leaves SDA released.

The register pointer is loaded by the first data byte of a write transfer. Each later byte of that transfer is stored at the pointer. A read transfer sends bytes back from the pointer, MSB first. The pointer steps by one after each byte moved in either direction and wraps from the top of the bank to zero, so a burst may be of any length. Reset leaves the pointer as it was. A controller must therefore write the pointer before it relies on the read address.

Every register appears on a wide parallel output. For each register, a select bit lets user logic supply a status byte that the bus reads in place of the stored value.

Top module: `i2c_rb_top`

## Requirements
- R1: After reset every register byte on `reg_q` is 0x00 and `sda_oe` is 0.
- R2: The block drives `sda_oe`=1 during the ninth SCL pulse after an address byte only when its upper seven bits equal `DEV_ADDR` (default 7'h3C; bit 0 is 1 for read, 0 for write). For any other address, `sda_oe` stays 0 until the next START.
- R3: The first data byte of a write transfer loads the register pointer and is not stored in any register.
- R4: Each later byte of a write transfer is stored at the pointer, and the pointer then steps by one. Each such byte is acknowledged with `sda_oe`=1 during its ninth SCL pulse.
- R5: A read transfer returns the byte at the pointer, MSB first, with the pointer stepping by one after each byte.
- R6: The pointer wraps from 255 to 0 in both write and read bursts, and a burst has no length limit.
- R7: Reset does not change the register pointer.
- R8: When `status_sel[i]` is 1, reads of register i return `status_i[8*i+7:8*i]`. The stored value on `reg_q` is unaffected.
- R9: A NACK from the controller after a read byte ends the read, and `sda_oe` stays 0 until the next START.
- R10: A repeated START restarts the address phase, so a pointer write followed by a repeated-START read returns data from the new pointer.
- R11: `sda_oe` changes only while SCL is low.
- R12: A transfer to a non-matching address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| status_i | input | 8*2**ADDR_W | Status bytes from user logic, byte i at bits 8*i+7:8*i |
| status_sel | input | 2**ADDR_W | Per-register read-source select (1 = status byte) |
| reg_q | output | 8*2**ADDR_W | Stored register bytes, byte i at bits 8*i+7:8*i |

## Verification
The assertions assume a well-behaved controller. It keeps SDA steady while SCL is high, except when it makes a START or STOP. It holds each SCL phase for several system clocks, longer than the two-flop sampling delay. It never makes a START or STOP while the target holds SDA low. The bench keeps within these limits. Its controller model splits every SCL period into four quarters of ten system clocks each, changes SDA only in the middle of the low phase, and releases SDA before every ninth pulse that belongs to the target.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } eng_state_t;
endpackage

// File: rtl/i2c_rb_lines.sv
// Bus line sampling and START/STOP/edge detection.
module i2c_rb_lines #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff;
  logic [SYNC_STAGES-1:0] sda_ff;
  logic                   scl_d;
  logic                   sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rb_engine.sv
// Byte-level target state machine and register pointer.
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3C,
  parameter int         ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              ptr_adv,
  output logic              ptr_load
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  eng_state_t        state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [BYTE_W-1:0] tx, tx_n;
  logic              rw, rw_n;
  logic              first, first_n;
  logic              acked, acked_n;
  logic [ADDR_W-1:0] ptr_n;
  logic              ptr_en;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    sh_n     = sh;
    tx_n     = tx;
    rw_n     = rw;
    first_n  = first;
    acked_n  = acked;
    wr_en    = 1'b0;
    ptr_adv  = 1'b0;
    ptr_load = 1'b0;
    if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = CNT_W'(cnt + 1'b1);
          end else if (scl_fall && cnt == FULL) begin
            if (sh[BYTE_W-1:1] == DEV_ADDR) begin
              state_n = ST_AACK;
              rw_n    = sh[0];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              state_n = ST_RDATA;
              tx_n    = rd_byte;
            end else begin
              state_n = ST_WDATA;
              first_n = 1'b1;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = CNT_W'(cnt + 1'b1);
          end else if (scl_fall && cnt == FULL) begin
            state_n = ST_WACK;
            if (first) begin
              ptr_load = 1'b1;
              first_n  = 1'b0;
            end else begin
              wr_en   = 1'b1;
              ptr_adv = 1'b1;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state_n = ST_WDATA;
            cnt_n   = '0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            cnt_n = CNT_W'(cnt + 1'b1);
            if (cnt == LAST_BIT) begin
              state_n = ST_RACK;
              ptr_adv = 1'b1;
            end else begin
              tx_n = {tx[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            acked_n = ~sda_s;
          end else if (scl_fall) begin
            if (acked) begin
              state_n = ST_RDATA;
              cnt_n   = '0;
              tx_n    = rd_byte;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      tx    <= '0;
      rw    <= 1'b0;
      first <= 1'b0;
      acked <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      sh    <= sh_n;
      tx    <= tx_n;
      rw    <= rw_n;
      first <= first_n;
      acked <= acked_n;
    end
  end

  // Pointer: deliberately outside the reset domain.
  assign ptr_en = ptr_load | ptr_adv;
  assign ptr_n  = ptr_load ? sh[ADDR_W-1:0] : ADDR_W'(ptr + 1'b1);

  always_ff @(posedge clk) begin
    if (ptr_en) begin
      ptr <= ptr_n;
    end
  end

  assign wr_data = sh;

  always_comb begin
    case (state)
      ST_AACK, ST_WACK: sda_oe = 1'b1;
      ST_RDATA:         sda_oe = ~tx[BYTE_W-1];
      default:          sda_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_rb_bank.sv
// Register storage and read-source selection.
module i2c_rb_bank
  import i2c_rb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        ptr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [BYTE_W*(2**ADDR_W)-1:0] status_i,
  input  logic [(2**ADDR_W)-1:0]   status_sel,
  output logic [BYTE_W*(2**ADDR_W)-1:0] reg_q,
  output logic [BYTE_W-1:0]        rd_byte
);
  localparam int NREG = 2 ** ADDR_W;

  logic [BYTE_W-1:0] mem [NREG];
  logic [BYTE_W-1:0] src [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic hit;
    assign hit = wr_en && (ptr == ADDR_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[gi] <= '0;
      end else if (hit) begin
        mem[gi] <= wr_data;
      end
    end

    assign reg_q[gi*BYTE_W +: BYTE_W] = mem[gi];
    assign src[gi] = status_sel[gi] ? status_i[gi*BYTE_W +: BYTE_W] : mem[gi];
  end

  assign rd_byte = src[ptr];
endmodule

// File: rtl/i2c_rb_top.sv
module i2c_rb_top
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3C,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_i,
  input  logic                          sda_i,
  output logic                          sda_oe,
  input  logic [BYTE_W*(2**ADDR_W)-1:0] status_i,
  input  logic [(2**ADDR_W)-1:0]        status_sel,
  output logic [BYTE_W*(2**ADDR_W)-1:0] reg_q
);
  logic [1:0]        rst_ff;
  logic              rst_sync_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en, ptr_adv, ptr_load;
  logic [BYTE_W-1:0] wr_data, rd_byte;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff <= 2'b00;
    end else begin
      rst_ff <= {rst_ff[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_ff[1];

  i2c_rb_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rb_engine #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .ptr_adv   (ptr_adv),
    .ptr_load  (ptr_load)
  );

  i2c_rb_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .ptr        (ptr),
    .wr_data    (wr_data),
    .status_i   (status_i),
    .status_sel (status_sel),
    .reg_q      (reg_q),
    .rd_byte    (rd_byte)
  );
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk
  import i2c_rb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          scl_s,
  input logic                          sda_oe,
  input logic                          stop_det,
  input logic                          wr_en,
  input logic [BYTE_W-1:0]             wr_data,
  input logic [ADDR_W-1:0]             ptr,
  input logic                          ptr_adv,
  input logic                          ptr_load,
  input logic [BYTE_W*(2**ADDR_W)-1:0] reg_q
);
  logic [ADDR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    ptr_q  <= ptr;
    data_q <= wr_data;
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)) else $error("oe moved with SCL high"); // R11

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> reg_q[{ptr_q, 3'b000} +: BYTE_W] == data_q) else $error("write lost"); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv |=> ptr == ADDR_W'($past(ptr) + 1'b1)) else $error("pointer step"); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_adv && !ptr_load) |=> $stable(ptr)) else $error("pointer drift"); // R7

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe) else $error("held SDA after STOP"); // R9
endmodule

bind i2c_rb_top i2c_rb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .stop_det (stop_det),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .ptr      (ptr),
  .ptr_adv  (ptr_adv),
  .ptr_load (ptr_load),
  .reg_q    (reg_q)
);

// File: tb/i2c_rb_top_bench.sv
module i2c_rb_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int ADDR_W     = 8;
  localparam int NREG       = 2 ** ADDR_W;
  localparam logic [7:0] AW = 8'h78;
  localparam logic [7:0] AR = 8'h79;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [8*NREG-1:0] status_i;
  logic [NREG-1:0]   status_sel;
  logic [8*NREG-1:0] reg_q;

  int compared = 0;
  int mismatched = 0;
  int oe_cnt = 0;
  int bad_chg = 0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_rb_top u_i2c_rb_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .status_i   (status_i),
    .status_sel (status_sel),
    .reg_q      (reg_q)
  );

  // R11 observer: target pull-down must not move while SCL is high.
  always @(posedge clk) begin
    if (rst_n) begin
      if (sda_oe !== oe_prev && scl_m) bad_chg++;
      if (sda_oe) oe_cnt++;
    end
    oe_prev = sda_oe;
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (got_q.size() != 0 && exp_q.size() != 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (g !== e) begin
        mismatched++;
        $display("FAIL %s read byte: actual=%02h expected=%02h", t, g, e);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return reg_q[i*8 +: 8];
  endfunction

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; waitq();
    scl_m = 1'b1; waitq(); waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    b = sda_line; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic [7:0] exp, input string req, input logic give_ack);
    logic [7:0] v;
    logic b;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
    got_q.push_back(v);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start();
    put_byte(AW, a); chk("R2 write address ack", a, 1);
    put_byte(p, a);  chk("R3 pointer byte ack", a, 1);
  endtask

  initial begin
    logic a, b;
    logic [8*NREG-1:0] snap;
    int oe0;
    for (int i = 0; i < NREG; i++) status_i[i*8 +: 8] = 8'(i) ^ 8'h5A;
    status_sel = '0;
    status_sel[8'h30] = 1'b1;
    status_sel[8'h40] = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 reg_q cleared", (reg_q == '0), 1);
    chk("R1 sda_oe idle", sda_oe, 0);

    // R3: pointer-only write stores nothing
    set_ptr(8'h20);
    bus_stop();
    chk("R3 pointer byte not stored", (reg_q == '0), 1);

    // R4: burst write
    set_ptr(8'h10);
    put_byte(8'h11, a); chk("R4 data ack", a, 1);
    put_byte(8'h22, a); chk("R4 data ack", a, 1);
    put_byte(8'h33, a); chk("R4 data ack", a, 1);
    bus_stop();
    chk("R4 reg 10", reg_at(8'h10), 8'h11);
    chk("R4 reg 11", reg_at(8'h11), 8'h22);
    chk("R4 reg 12", reg_at(8'h12), 8'h33);
    chk("R4 reg 0F untouched", reg_at(8'h0F), 8'h00);

    // R5/R10: pointer write, repeated START, read burst, R9 NACK release
    set_ptr(8'h10);
    bus_start();
    put_byte(AR, a); chk("R10 read address ack after Sr", a, 1);
    get_byte(8'h11, "R5", 1'b1);
    get_byte(8'h22, "R5", 1'b1);
    get_byte(8'h33, "R10", 1'b0);
    oe0 = oe_cnt;
    get_bit(b);
    chk("R9 line released after NACK", b, 1);
    chk("R9 no pull-down after NACK", oe_cnt - oe0, 0);
    bus_stop();

    // R6: wrap on write
    set_ptr(8'hFE);
    put_byte(8'hA1, a); put_byte(8'hA2, a); put_byte(8'hA3, a); put_byte(8'hA4, a);
    chk("R6 last write ack", a, 1);
    bus_stop();
    chk("R6 reg FE", reg_at(8'hFE), 8'hA1);
    chk("R6 reg FF", reg_at(8'hFF), 8'hA2);
    chk("R6 reg 00", reg_at(8'h00), 8'hA3);
    chk("R6 reg 01", reg_at(8'h01), 8'hA4);

    // R6: wrap on read
    set_ptr(8'hFF);
    bus_start();
    put_byte(AR, a);
    get_byte(8'hA2, "R6", 1'b1);
    get_byte(8'hA3, "R6", 1'b1);
    get_byte(8'hA4, "R6", 1'b0);
    bus_stop();

    // R2/R12: foreign address
    snap = reg_q;
    oe0 = oe_cnt;
    bus_start();
    put_byte(8'hA0, a); chk("R2 foreign address not acked", a, 0);
    put_byte(8'h05, a);
    put_byte(8'h99, a);
    bus_stop();
    chk("R2 no pull-down for foreign address", oe_cnt - oe0, 0);
    chk("R12 registers unchanged", (reg_q == snap), 1);

    // R8: status select
    set_ptr(8'h30);
    put_byte(8'h77, a);
    bus_stop();
    chk("R8 stored value on reg_q", reg_at(8'h30), 8'h77);
    set_ptr(8'h30);
    bus_start();
    put_byte(AR, a);
    get_byte(8'h6A, "R8", 1'b1);
    get_byte(8'h00, "R8", 1'b0);
    bus_stop();

    // R7: pointer survives reset
    set_ptr(8'h40);
    bus_stop();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reg_q cleared after second reset", (reg_q == '0), 1);
    bus_start();
    put_byte(AR, a); chk("R2 read address ack", a, 1);
    get_byte(8'h1A, "R7", 1'b0);
    bus_stop();

    repeat (20) @(negedge clk);
    chk("R11 no pull-down change with SCL high", bad_chg, 0);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule